// File: doc/BRIEF.md
# Seat Belt Warning Controller

This controller watches an ignition key switch and a seat belt switch and drives a warning alarm. When the key is switched on, a grace period begins. If the belt is still open when the grace period runs out, the alarm sounds, but only until a fixed time measured from that same key-on moment has passed. Fastening the belt or switching the key off ends the sequence at any point, during the grace period or while the alarm sounds.

The block works in whole seconds. It counts pulses on a one-cycle `sec_tick` input, and each pulse stands for one second. The tick source, switch debouncing and sound generation all sit outside the block. The controller has three states. `ST_OFF` is idle. `ST_WAIT` is the grace period. `ST_ALARM` is the sounding interval. There are six transitions:
- KEY_ON takes `ST_OFF` to `ST_WAIT`.
- WAIT_CANCEL takes `ST_WAIT` back to `ST_OFF`.
- WAIT_EXPIRE takes `ST_WAIT` to `ST_ALARM`.
- ALARM_TIMEOUT takes `ST_ALARM` to `ST_OFF`.
- ALARM_CANCEL takes `ST_ALARM` to `ST_OFF`.
- HOLD keeps the current state when no condition is met. HOLD changes no output.

Top module: `seat_belt_warn`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters `ST_OFF`, clears the seconds counter and drives `alarm_out` low. The key edge detector follows `key_in` during reset, so a key that is already high when reset is released does not count as a key-on event.
- R2: KEY_ON: in `ST_OFF`, a rising edge of `key_in` (high now, low in the previous cycle) moves the block to `ST_WAIT`. The seconds counter starts from zero at that point.
- R3: WAIT_CANCEL: in `ST_WAIT`, `key_in` low or `belt_in` high returns the block to `ST_OFF`. No alarm follows, however many ticks arrive afterwards.
- R4: WAIT_EXPIRE: in `ST_WAIT`, the tick that brings the counter to GRACE_S (5 by default) is followed, one clock after it is sampled, by `alarm_out` going high. `alarm_out` is still low in the cycle right after that tick.
- R5: ALARM_TIMEOUT: in `ST_ALARM`, the tick that brings the counter to LIMIT_S (10 by default, counted from key-on) is followed, one clock after it is sampled, by `alarm_out` going low.
- R6: ALARM_CANCEL by belt: `belt_in` high in `ST_ALARM` drives `alarm_out` low at the next clock edge.
- R7: ALARM_CANCEL by key: `key_in` low in `ST_ALARM` drives `alarm_out` low at the next clock edge.
- R8: If the expiring tick and `belt_in` high are sampled at the same edge in `ST_WAIT`, the belt wins, and `alarm_out` never rises.
- R9: Ticks received in `ST_OFF` are not counted. After a key-on, exactly GRACE_S further ticks are still needed to raise the alarm.
- R10: `alarm_out` is high exactly while the block is in `ST_ALARM`. The seconds counter never exceeds LIMIT_S.
- R11: After a sequence ends, a key that stays high does not start a new one. Only a new rising edge of `key_in` does that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_in | input | 1 | Ignition key level, 1 = on |
| belt_in | input | 1 | Seat belt level, 1 = fastened |
| sec_tick | input | 1 | One-cycle pulse, one per second |
| alarm_out | output | 1 | Warning alarm level, 1 = sounding |

## Verification
The bench builds the block with the default values, GRACE_S = 5 and LIMIT_S = 10. With these values both the expiry edge and the timeout edge can be reached within a few dozen ticks. This puts every transition within reach, including the expiry tick that arrives in the same cycle as the belt, and cancels at the first and last second of each state. Because ticks are spaced two clocks apart, the bench can see separately the cycle in which the counter reaches a limit and the cycle in which the state follows it.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ALARM = 2'd2
    } sbw_state_e;

endpackage

// File: rtl/sbw_key_edge.sv
// Rising-edge detector for the ignition key level.
// The history register follows the input during reset, so a key that is
// already on when reset is released does not produce an event.
module sbw_key_edge (
    input  logic clk,
    input  logic rst,
    input  logic key_in,
    output logic key_rise
);

    logic key_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_prev <= key_in;
        end else begin
            key_prev <= key_in;
        end
    end

    assign key_rise = key_in & ~key_prev & ~rst;

endmodule

// File: rtl/sbw_sec_timer.sv
// Seconds counter: counts tick pulses while enabled, holds at the limit,
// clears when disabled or on reset.
module sbw_sec_timer #(
    parameter int unsigned LIMIT_S = 10,
    localparam int unsigned CW     = $clog2(LIMIT_S + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          sec_tick,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] CMAX = CW'(LIMIT_S);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (sec_tick && (count != CMAX)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sbw_fsm.sv
// Three-state warning sequencer.
module sbw_fsm
    import sbw_pkg::*;
#(
    parameter int unsigned GRACE_S = 5,
    parameter int unsigned LIMIT_S = 10,
    localparam int unsigned CW     = $clog2(LIMIT_S + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          key_rise,
    input  logic          key_in,
    input  logic          belt_in,
    input  logic [CW-1:0] count,
    output sbw_state_e    state,
    output logic          timer_run,
    output logic          alarm_out
);

    localparam logic [CW-1:0] GRACE_C = CW'(GRACE_S);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT_S);

    sbw_state_e state_nx;
    logic       cancel;
    logic       grace_done;
    logic       limit_done;

    assign cancel     = belt_in | ~key_in;
    assign grace_done = (count >= GRACE_C);
    assign limit_done = (count >= LIMIT_C);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (key_rise) begin
                    state_nx = ST_WAIT;           // KEY_ON
                end
            end
            ST_WAIT: begin
                if (cancel) begin
                    state_nx = ST_OFF;            // WAIT_CANCEL (wins over expiry)
                end else if (grace_done) begin
                    state_nx = ST_ALARM;          // WAIT_EXPIRE
                end
            end
            ST_ALARM: begin
                if (cancel || limit_done) begin
                    state_nx = ST_OFF;            // ALARM_CANCEL / ALARM_TIMEOUT
                end
            end
            default: begin
                state_nx = ST_OFF;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // Output register: alarm level follows the state entered
    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_out <= 1'b0;
        end else begin
            alarm_out <= (state_nx == ST_ALARM);
        end
    end

    assign timer_run = (state != ST_OFF);

endmodule

// File: rtl/seat_belt_warn.sv
module seat_belt_warn
    import sbw_pkg::*;
#(
    parameter int unsigned GRACE_S = 5,
    parameter int unsigned LIMIT_S = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic key_in,
    input  logic belt_in,
    input  logic sec_tick,
    output logic alarm_out
);

    localparam int unsigned CW = $clog2(LIMIT_S + 1);

    logic          key_rise;
    logic          timer_run;
    logic [CW-1:0] count_w;
    sbw_state_e    state_w;

    sbw_key_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .key_in   (key_in),
        .key_rise (key_rise)
    );

    sbw_sec_timer #(.LIMIT_S(LIMIT_S)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (timer_run),
        .sec_tick (sec_tick),
        .count    (count_w)
    );

    sbw_fsm #(.GRACE_S(GRACE_S), .LIMIT_S(LIMIT_S)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .key_rise  (key_rise),
        .key_in    (key_in),
        .belt_in   (belt_in),
        .count     (count_w),
        .state     (state_w),
        .timer_run (timer_run),
        .alarm_out (alarm_out)
    );

endmodule

// File: rtl/sbw_checker.sv
module sbw_checker
    import sbw_pkg::*;
#(
    parameter int unsigned GRACE_S = 5,
    parameter int unsigned LIMIT_S = 10,
    localparam int unsigned CW     = $clog2(LIMIT_S + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          key_in,
    input logic          belt_in,
    input logic          alarm_out,
    input sbw_state_e    state,
    input logic [CW-1:0] count
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (state == ST_OFF && !alarm_out && count == '0)); // R1

    AST_NO_START_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && !(key_in && !$past(key_in))) |=> state == ST_OFF); // R11

    AST_BELT_CANCELS: assert property (@(posedge clk) disable iff (rst)
        (state != ST_OFF && belt_in) |=> (state == ST_OFF && !alarm_out)); // R6

    AST_KEY_OFF_CANCELS: assert property (@(posedge clk) disable iff (rst)
        (state != ST_OFF && !key_in) |=> (state == ST_OFF && !alarm_out)); // R7

    AST_ALARM_IS_STATE: assert property (@(posedge clk) disable iff (rst)
        alarm_out == (state == ST_ALARM)); // R10

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(LIMIT_S)); // R10

    AST_ALARM_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_out) |-> ($past(count) >= CW'(GRACE_S) && !$past(belt_in))); // R4

endmodule

bind seat_belt_warn sbw_checker #(.GRACE_S(GRACE_S), .LIMIT_S(LIMIT_S)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .key_in    (key_in),
    .belt_in   (belt_in),
    .alarm_out (alarm_out),
    .state     (state_w),
    .count     (count_w)
);

// File: tb/seat_belt_warn_tb.sv
module seat_belt_warn_tb;

    localparam int GRACE = 5;
    localparam int LIMIT = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_in = 1'b0;
    logic belt_in = 1'b0;
    logic sec_tick = 1'b0;
    logic alarm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    seat_belt_warn #(.GRACE_S(GRACE), .LIMIT_S(LIMIT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .key_in    (key_in),
        .belt_in   (belt_in),
        .sec_tick  (sec_tick),
        .alarm_out (alarm_out)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (alarm_out !== exp) begin
            n_bad++;
            $display("FAIL %s: alarm_out=%b expected %b at %0t", req, alarm_out, exp, $time);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic key_on();
        @(negedge clk) key_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic quiet();
        @(negedge clk);
        key_in = 1'b0; belt_in = 1'b0; sec_tick = 1'b0;
        clocks(2);
    endtask

    // R1: reset state, key held high across reset is not an event
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; key_in = 1'b1;
        clocks(3);
        chk("R1 reset", 1'b0);
        rst = 1'b0;
        ticks(GRACE + 2);
        chk("R1 key high at reset is no event", 1'b0);
        quiet();
    endtask

    // R2, R4, R5, R11: full sequence
    task automatic t_full();
        key_on();
        ticks(GRACE - 1);
        chk("R2 grace running", 1'b0);
        tick();
        chk("R4 not yet raised", 1'b0);
        clocks(1);
        chk("R4 alarm raised", 1'b1);
        ticks(LIMIT - GRACE - 1);
        chk("R5 alarm holds", 1'b1);
        tick();
        chk("R5 still high before timeout", 1'b1);
        clocks(1);
        chk("R5 timeout drops alarm", 1'b0);
        ticks(GRACE + 2);
        chk("R11 held key no restart", 1'b0);
        quiet();
    endtask

    // R3: belt and key-off cancel the grace period
    task automatic t_wait_cancel();
        key_on();
        ticks(GRACE - 1);
        @(negedge clk) belt_in = 1'b1;
        @(negedge clk) belt_in = 1'b0;
        ticks(GRACE + 1);
        chk("R3 belt cancels wait", 1'b0);
        quiet();
        key_on();
        ticks(2);
        @(negedge clk) key_in = 1'b0;
        @(negedge clk) key_in = 1'b1;   // new edge starts a fresh wait
        ticks(GRACE - 1);
        chk("R3 key off cancels wait, restart fresh", 1'b0);
        tick();
        clocks(1);
        chk("R2 fresh start counts from zero", 1'b1);
        quiet();
    endtask

    // R6: belt ends the alarm
    task automatic t_alarm_belt();
        key_on();
        ticks(GRACE);
        clocks(1);
        chk("R6 alarm on before belt", 1'b1);
        belt_in = 1'b1;
        clocks(1);
        chk("R6 belt drops alarm", 1'b0);
        belt_in = 1'b0;
        ticks(3);
        chk("R6 stays off", 1'b0);
        quiet();
    endtask

    // R7: key off ends the alarm
    task automatic t_alarm_key();
        key_on();
        ticks(GRACE + 2);
        chk("R7 alarm on before key off", 1'b1);
        key_in = 1'b0;
        clocks(1);
        chk("R7 key off drops alarm", 1'b0);
        quiet();
    endtask

    // R8: expiry and belt in the same cycle
    task automatic t_race();
        key_on();
        ticks(GRACE - 1);
        @(negedge clk) begin sec_tick = 1'b1; end
        @(negedge clk) begin sec_tick = 1'b0; belt_in = 1'b1; end
        // belt sampled at the edge where the counter already reads GRACE
        clocks(1);
        chk("R8 belt wins over expiry", 1'b0);
        belt_in = 1'b0;
        clocks(2);
        chk("R8 no alarm later", 1'b0);
        quiet();
    endtask

    // R9: ticks in off are ignored
    task automatic t_idle_ticks();
        ticks(8);
        chk("R9 idle ticks no alarm", 1'b0);
        key_on();
        ticks(GRACE - 1);
        clocks(1);
        chk("R9 idle ticks not counted", 1'b0);
        tick();
        clocks(1);
        chk("R9 alarm after full grace", 1'b1);
        quiet();
    endtask

    initial begin
        clocks(2);
        t_reset();
        t_full();
        t_wait_cancel();
        t_alarm_belt();
        t_alarm_key();
        t_race();
        t_idle_ticks();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule